// File: doc/BRIEF.md
# I2C Read-Only Target Engine

This block is a 7-bit-addressed I2C target that answers read requests from a bus master. It samples SCL and SDA through synchronizers and detects Start, repeated Start and Stop. It shifts in the address byte and acknowledges it when the address matches and the direction bit asks for a read. It then holds SCL low until the host side hands over the next byte. Bytes go out MSB first, changing only while SCL is low. The master's acknowledge is taken on the rising edge of the ninth clock. An ACK makes the block stretch the clock again for the next byte. A NACK sends it back to idle.

On the host side there are two streams. The outgoing byte stream (`tx_valid`/`tx_ready`/`tx_data`) applies back-pressure in the usual way. `tx_ready` is high only while the block is stretching SCL and waiting for data. A beat is accepted on any clock where both are high, and that beat also releases SCL. The host may hold `tx_valid` high for as long as it likes; the block takes data only when it needs it. The incoming stream (`rx_valid`/`rx_ready`/`rx_data`) carries each acknowledged read address byte. It stays valid until the host pops it. A newer address overwrites an unread one. Per-byte events, the acknowledge status and slave-side bus collisions are reported on plain status pins, each with its own clear or enable.

Both bus outputs are open-drain enables: a 1 pulls the line low, and a 0 releases it. The block never drives a line high.

Top module: `i2cst_target`

## Requirements
- R1: After reset, neither bus line is pulled low, and `tx_ready`, `rx_valid`, `byte_irq`, `bus_col`, `rd_mode` and `ack_stat` are all 0.
- R2: The address byte is received MSB first: address in bits 7:1, R/W in bit 0. When bits 7:1 equal `own_addr` and bit 0 is 1, SDA is pulled low for the ninth clock (ACK), `rd_mode` goes to 1, and the whole byte appears on `rx_data` with `rx_valid` high. It stays there until a clock with `rx_ready` high.
- R3: After the read address is acknowledged, SCL is held low and `tx_ready` is 1 until a `tx_valid` beat is accepted. The clock after acceptance, SCL is released.
- R4: Each accepted byte is shifted out MSB first. SDA changes only after a falling SCL edge and stays steady while SCL is high.
- R5: The level on SDA at the rising edge of the ninth clock of each data byte is stored in `ack_stat` (0 = ACK, 1 = NACK). `ack_stat` changes only while SCL is high.
- R6: After an ACKed data byte, SCL is held low again and `tx_ready` rises for the next byte.
- R7: After a NACKed data byte, SCL is not held. `rd_mode` returns to 0, and the block ignores the bus until the next Start.
- R8: `byte_irq` is set at the falling edge of the ninth clock of every byte, including the address byte and a NACKed final byte. It stays set until a clock with `irq_clr` high.
- R9: With `col_en` = 1, if SDA reads low at a rising SCL edge while the block is releasing it for a 1 data bit, `bus_col` is set and the transfer is abandoned: the block goes idle, `byte_irq` is not set for that byte, and nothing is driven. With `col_en` = 0 the mismatch has no effect. `bus_col` stays set until `col_clr`.
- R10: An address byte whose bits 7:1 differ from `own_addr`, or whose bit 0 is 0, is not acknowledged. The block drives nothing until the next Start.
- R11: A Start or repeated Start, even in the middle of a byte, restarts address reception from the first bit. With `start_irq_en` = 1, every Start also sets `byte_irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| own_addr | input | 7 | Address this target answers to |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (clock stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| tx_valid | input | 1 | Host offers the next byte to send |
| tx_ready | output | 1 | Block waits for a byte; SCL is held |
| tx_data | input | 8 | Byte to send |
| rx_valid | output | 1 | An acknowledged address byte is waiting |
| rx_ready | input | 1 | Host pops the address byte |
| rx_data | output | 8 | Received address byte |
| start_irq_en | input | 1 | Set `byte_irq` on every Start |
| byte_irq | output | 1 | Per-byte event flag |
| irq_clr | input | 1 | Clears `byte_irq` |
| col_en | input | 1 | Enables slave bus-collision detection |
| bus_col | output | 1 | Bus collision seen |
| col_clr | input | 1 | Clears `bus_col` |
| ack_stat | output | 1 | Last acknowledge from the master (1 = NACK) |
| rd_mode | output | 1 | Addressed for a read |

## Verification
A wrong transfer state shows at the ports within one SCL period. A miscounted bit position either shifts the received byte seen by the master, or moves the ACK slot so the master reads the wrong acknowledge on the ninth pulse. A state that forgets to stretch shows as a master clock that runs on while `tx_ready` is high. A state that forgets to go idle after a NACK or a collision leaves `rd_mode` or `byte_irq` at the wrong level before the next Start. SDA edges while SCL is high are caught on the very clock they happen, because such an edge would be read as a false Start or Stop.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_ADDR,
    XS_ADDR_ACK,
    XS_HOLD,
    XS_SHIFT,
    XS_MACK
  } xfer_state_e;

  localparam int LINE_SCL = 0;
  localparam int LINE_SDA = 1;
  localparam int N_LINES  = 2;

endpackage

// File: rtl/i2cst_line_sync.sv
module i2cst_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // idle bus lines float high, so reset to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      prev_q  <= 1'b1;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], raw_i};
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/i2cst_bus_cond.sv
module i2cst_bus_cond (
  input  logic scl_lvl,
  input  logic scl_rise,
  input  logic sda_rise,
  input  logic sda_fall,
  output logic start_o,
  output logic stop_o
);
  logic scl_steady_high;

  // SCL high on this sample and on the one before
  assign scl_steady_high = scl_lvl & ~scl_rise;
  assign start_o = scl_steady_high & sda_fall;
  assign stop_o  = scl_steady_high & sda_rise;
endmodule

// File: rtl/i2cst_xfer_fsm.sv
module i2cst_xfer_fsm
  import i2cst_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              col_en,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_lvl,
  input  logic              cond_start,
  input  logic              cond_stop,
  input  logic              tx_valid,
  input  logic [ADDR_W:0]   tx_data,
  output logic              tx_ready,
  output logic              scl_low,
  output logic              sda_low,
  output logic              rd_mode,
  output logic              addr_load,
  output logic [ADDR_W:0]   addr_byte,
  output logic              byte_done,
  output logic              ack_smp,
  output logic              ack_val,
  output logic              col_hit
);
  localparam int BYTE_W = ADDR_W + 1;
  localparam int CNT_W  = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

  xfer_state_e       state_q, state_n;
  logic [BYTE_W-1:0] shreg_q, shreg_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              sdl_q, sdl_n;
  logic              rdm_q, rdm_n;
  logic              nack_q, nack_n;
  logic              addr_hit;

  assign addr_hit = (shreg_q[BYTE_W-1:1] == own_addr) & shreg_q[0];

  always_comb begin
    state_n   = state_q;
    shreg_n   = shreg_q;
    cnt_n     = cnt_q;
    sdl_n     = sdl_q;
    rdm_n     = rdm_q;
    nack_n    = nack_q;
    addr_load = 1'b0;
    byte_done = 1'b0;
    ack_smp   = 1'b0;
    ack_val   = 1'b0;
    col_hit   = 1'b0;
    if (cond_start) begin
      state_n = XS_ADDR;
      cnt_n   = '0;
      sdl_n   = 1'b0;
      rdm_n   = 1'b0;
    end else if (cond_stop) begin
      state_n = XS_IDLE;
      sdl_n   = 1'b0;
      rdm_n   = 1'b0;
    end else begin
      unique case (state_q)
        XS_IDLE: ;
        XS_ADDR: begin
          if (scl_rise && cnt_q != CNT_FULL) begin
            shreg_n = {shreg_q[BYTE_W-2:0], sda_lvl};
            cnt_n   = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == CNT_FULL) begin
            if (addr_hit) begin
              sdl_n   = 1'b1;
              state_n = XS_ADDR_ACK;
            end else begin
              state_n = XS_IDLE;
            end
          end
        end
        XS_ADDR_ACK: begin
          if (scl_fall) begin
            sdl_n     = 1'b0;
            addr_load = 1'b1;
            byte_done = 1'b1;
            rdm_n     = 1'b1;
            state_n   = XS_HOLD;
          end
        end
        XS_HOLD: begin
          if (tx_valid) begin
            shreg_n = tx_data;
            sdl_n   = ~tx_data[BYTE_W-1];
            cnt_n   = '0;
            state_n = XS_SHIFT;
          end
        end
        XS_SHIFT: begin
          if (scl_rise) begin
            if (col_en && !sdl_q && !sda_lvl) begin
              col_hit = 1'b1;
              rdm_n   = 1'b0;
              state_n = XS_IDLE;
            end
          end else if (scl_fall) begin
            if (cnt_q == CNT_LAST) begin
              sdl_n   = 1'b0;
              cnt_n   = '0;
              state_n = XS_MACK;
            end else begin
              shreg_n = {shreg_q[BYTE_W-2:0], 1'b0};
              sdl_n   = ~shreg_q[BYTE_W-2];
              cnt_n   = cnt_q + 1'b1;
            end
          end
        end
        XS_MACK: begin
          if (scl_rise) begin
            ack_smp = 1'b1;
            ack_val = sda_lvl;
            nack_n  = sda_lvl;
          end else if (scl_fall) begin
            byte_done = 1'b1;
            if (nack_q) begin
              rdm_n   = 1'b0;
              state_n = XS_IDLE;
            end else begin
              state_n = XS_HOLD;
            end
          end
        end
        default: state_n = XS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= XS_IDLE;
      shreg_q <= '0;
      cnt_q   <= '0;
      sdl_q   <= 1'b0;
      rdm_q   <= 1'b0;
      nack_q  <= 1'b0;
    end else begin
      state_q <= state_n;
      shreg_q <= shreg_n;
      cnt_q   <= cnt_n;
      sdl_q   <= sdl_n;
      rdm_q   <= rdm_n;
      nack_q  <= nack_n;
    end
  end

  assign tx_ready  = (state_q == XS_HOLD);
  assign scl_low   = (state_q == XS_HOLD);
  assign sda_low   = sdl_q;
  assign rd_mode   = rdm_q;
  assign addr_byte = shreg_q;
endmodule

// File: rtl/i2cst_host_side.sv
module i2cst_host_side #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [BYTE_W-1:0] addr_byte,
  input  logic              rx_ready,
  output logic              rx_valid,
  output logic [BYTE_W-1:0] rx_data,
  input  logic              byte_done,
  input  logic              start_seen,
  input  logic              start_irq_en,
  input  logic              irq_clr,
  output logic              byte_irq,
  input  logic              col_hit,
  input  logic              col_clr,
  output logic              bus_col,
  input  logic              ack_smp,
  input  logic              ack_val,
  output logic              ack_stat
);
  logic irq_set;

  assign irq_set = byte_done | (start_seen & start_irq_en);

  // new events win over a clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      byte_irq <= 1'b0;
      bus_col  <= 1'b0;
      ack_stat <= 1'b0;
    end else begin
      if (addr_load) begin
        rx_valid <= 1'b1;
        rx_data  <= addr_byte;
      end else if (rx_ready) begin
        rx_valid <= 1'b0;
      end
      if (irq_set)      byte_irq <= 1'b1;
      else if (irq_clr) byte_irq <= 1'b0;
      if (col_hit)      bus_col <= 1'b1;
      else if (col_clr) bus_col <= 1'b0;
      if (ack_smp)      ack_stat <= ack_val;
    end
  end
endmodule

// File: rtl/i2cst_target.sv
module i2cst_target
  import i2cst_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] own_addr,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_oe,
  output logic              sda_oe,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [ADDR_W:0]   tx_data,
  output logic              rx_valid,
  input  logic              rx_ready,
  output logic [ADDR_W:0]   rx_data,
  input  logic              start_irq_en,
  output logic              byte_irq,
  input  logic              irq_clr,
  input  logic              col_en,
  output logic              bus_col,
  input  logic              col_clr,
  output logic              ack_stat,
  output logic              rd_mode
);
  localparam int BYTE_W = ADDR_W + 1;

  logic [N_LINES-1:0] raw_lines, lvl, rise, fall;
  logic               scl_lvl;
  logic               cond_start, cond_stop;
  logic               addr_load, byte_done, ack_smp, ack_val, col_hit;
  logic [BYTE_W-1:0]  addr_byte;

  assign raw_lines[LINE_SCL] = scl_i;
  assign raw_lines[LINE_SDA] = sda_i;

  for (genvar g = 0; g < N_LINES; g++) begin : g_sync
    i2cst_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (raw_lines[g]),
      .level_o (lvl[g]),
      .rise_o  (rise[g]),
      .fall_o  (fall[g])
    );
  end

  assign scl_lvl = lvl[LINE_SCL];

  i2cst_bus_cond u_cond (
    .scl_lvl  (scl_lvl),
    .scl_rise (rise[LINE_SCL]),
    .sda_rise (rise[LINE_SDA]),
    .sda_fall (fall[LINE_SDA]),
    .start_o  (cond_start),
    .stop_o   (cond_stop)
  );

  i2cst_xfer_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .own_addr   (own_addr),
    .col_en     (col_en),
    .scl_rise   (rise[LINE_SCL]),
    .scl_fall   (fall[LINE_SCL]),
    .sda_lvl    (lvl[LINE_SDA]),
    .cond_start (cond_start),
    .cond_stop  (cond_stop),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready),
    .scl_low    (scl_oe),
    .sda_low    (sda_oe),
    .rd_mode    (rd_mode),
    .addr_load  (addr_load),
    .addr_byte  (addr_byte),
    .byte_done  (byte_done),
    .ack_smp    (ack_smp),
    .ack_val    (ack_val),
    .col_hit    (col_hit)
  );

  i2cst_host_side #(.BYTE_W(BYTE_W)) u_host (
    .clk          (clk),
    .rst_n        (rst_n),
    .addr_load    (addr_load),
    .addr_byte    (addr_byte),
    .rx_ready     (rx_ready),
    .rx_valid     (rx_valid),
    .rx_data      (rx_data),
    .byte_done    (byte_done),
    .start_seen   (cond_start),
    .start_irq_en (start_irq_en),
    .irq_clr      (irq_clr),
    .byte_irq     (byte_irq),
    .col_hit      (col_hit),
    .col_clr      (col_clr),
    .bus_col      (bus_col),
    .ack_smp      (ack_smp),
    .ack_val      (ack_val),
    .ack_stat     (ack_stat)
  );
endmodule

// File: rtl/i2cst_target_chk.sv
module i2cst_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_lvl,
  input logic scl_oe,
  input logic sda_oe,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid,
  input logic rx_ready,
  input logic byte_irq,
  input logic irq_clr,
  input logic col_en,
  input logic bus_col,
  input logic ack_stat,
  input logic rd_mode
);
  AST_RX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && !rx_ready |=> rx_valid); // R2
  AST_LOAD_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !scl_oe); // R3
  AST_SDA_STEADY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    scl_lvl && $past(scl_lvl) |-> $stable(sda_oe)); // R4
  AST_ACK_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ack_stat) |-> scl_lvl); // R5
  AST_NO_STRETCH_UNADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_mode |-> !scl_oe); // R7
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    byte_irq && !irq_clr |=> byte_irq); // R8
  AST_COL_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_col) |-> $past(col_en)); // R9
  AST_COL_GOES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_col) |-> !sda_oe && !scl_oe && !rd_mode); // R9
endmodule

bind i2cst_target i2cst_target_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_lvl  (scl_lvl),
  .scl_oe   (scl_oe),
  .sda_oe   (sda_oe),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .rx_valid (rx_valid),
  .rx_ready (rx_ready),
  .byte_irq (byte_irq),
  .irq_clr  (irq_clr),
  .col_en   (col_en),
  .bus_col  (bus_col),
  .ack_stat (ack_stat),
  .rd_mode  (rd_mode)
);

// File: tb/tb_i2cst_target.sv
module tb_i2cst_target;
  localparam int T = 12;
  localparam logic [6:0] OWN = 7'h5A;
  localparam logic [7:0] RD_ADDR = {OWN, 1'b1};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1, sda_m = 1'b1;
  logic       scl_w, sda_w;
  logic       scl_oe, sda_oe;
  logic       tx_valid = 1'b0, tx_ready;
  logic [7:0] tx_data = '0;
  logic       rx_valid, rx_ready = 1'b0;
  logic [7:0] rx_data;
  logic       start_irq_en = 1'b0, byte_irq, irq_clr = 1'b0;
  logic       col_en = 1'b0, bus_col, col_clr = 1'b0;
  logic       ack_stat, rd_mode;
  int         n_tests = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  logic [7:0] got_byte;
  event       got_ev;

  always #10 clk = ~clk;

  assign scl_w = scl_m & ~scl_oe;
  assign sda_w = sda_m & ~sda_oe;

  i2cst_target dut (
    .clk(clk), .rst_n(rst_n), .own_addr(OWN), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
    .start_irq_en(start_irq_en), .byte_irq(byte_irq), .irq_clr(irq_clr),
    .col_en(col_en), .bus_col(bus_col), .col_clr(col_clr),
    .ack_stat(ack_stat), .rd_mode(rd_mode)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_start;
    sda_m = 1'b1; wait_cyc(T);
    scl_m = 1'b1; wait_cyc(T);
    sda_m = 1'b0; wait_cyc(T);
    scl_m = 1'b0; wait_cyc(T);
  endtask

  task automatic m_stop;
    sda_m = 1'b0; wait_cyc(T);
    scl_m = 1'b1; wait_cyc(T);
    sda_m = 1'b1; wait_cyc(T);
  endtask

  task automatic m_send_bit(input logic b);
    sda_m = b; wait_cyc(T);
    scl_m = 1'b1;
    while (!scl_w) @(negedge clk);
    wait_cyc(T);
    scl_m = 1'b0; wait_cyc(T);
  endtask

  task automatic m_recv_bit(input logic pull, output logic b);
    sda_m = ~pull; wait_cyc(T);
    scl_m = 1'b1;
    while (!scl_w) @(negedge clk);
    wait_cyc(T / 2);
    b = sda_w;
    wait_cyc(T / 2);
    scl_m = 1'b0; wait_cyc(T);
  endtask

  task automatic m_send_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) m_send_bit(v[i]);
    m_recv_bit(1'b0, ack);
  endtask

  task automatic m_recv_byte(input logic nack, input int force_idx, input logic score,
                             output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      m_recv_bit(i == force_idx, b);
      v[i] = b;
    end
    if (score) begin
      got_byte = v;
      -> got_ev;
    end
    m_send_bit(nack);
  endtask

  task automatic pulse_irq_clr;
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic pulse_rx_ready;
    rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0;
  endtask

  // driver: hands a byte to the block and records the expectation
  task automatic host_push(input logic [7:0] d, input logic score);
    while (!tx_ready) @(negedge clk);
    if (score) exp_q.push_back(d);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // monitor: compares what the master clocked out against the queue
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) chk("R4 unexpected byte", {24'h0, got_byte}, 32'h0);
      else chk("R4 byte MSB first", {24'h0, got_byte}, {24'h0, exp_q.pop_front()});
    end
  end

  task automatic rd_xfer(input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                         input int n, input logic junk);
    logic [7:0] d [3];
    d[0] = d0; d[1] = d1; d[2] = d2;
    fork
      begin
        logic a;
        logic [7:0] v;
        m_start;
        if (junk) begin
          m_send_bit(1'b1); m_send_bit(1'b0); m_send_bit(1'b1); m_send_bit(1'b1);
          m_start;
        end
        m_send_byte(RD_ADDR, a);
        chk(junk ? "R11 restart then ACK" : "R2 address ACK", {31'h0, a}, 32'h0);
        for (int i = 0; i < n; i++) m_recv_byte(i == n - 1, -1, 1'b1, v);
        m_stop;
      end
      begin
        for (int i = 0; i < n; i++) begin
          while (!tx_ready) @(negedge clk);
          if (i > 0) chk("R6 stretch after ACK", {30'h0, ack_stat, scl_oe}, 32'h1);
          pulse_irq_clr;
          host_push(d[i], 1'b1);
        end
      end
    join
    chk("R7 idle after NACK", {29'h0, rd_mode, scl_oe, ack_stat}, 32'h1);
    chk("R8 irq on NACKed byte", {31'h0, byte_irq}, 32'h1);
    pulse_irq_clr;
    pulse_rx_ready;
  endtask

  task automatic col_xfer(input logic en, input int idx);
    col_en = en;
    fork
      begin
        logic a;
        logic [7:0] v;
        m_start;
        m_send_byte(RD_ADDR, a);
        m_recv_byte(1'b1, idx, 1'b0, v);
        m_stop;
      end
      begin
        while (!tx_ready) @(negedge clk);
        pulse_irq_clr;
        host_push(8'hFF, 1'b0);
      end
    join
    if (en) chk("R9 collision abandons", {28'h0, bus_col, byte_irq, rd_mode, sda_oe}, 32'h8);
    else    chk("R9 disabled no effect", {28'h0, bus_col, byte_irq, rd_mode, sda_oe}, 32'h4);
    col_clr = 1'b1; @(negedge clk); col_clr = 1'b0;
    chk("R9 col_clr", {31'h0, bus_col}, 32'h0);
    pulse_irq_clr;
    pulse_rx_ready;
    col_en = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic a;
    logic [7:0] v;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R1 reset state",
        {25'h0, sda_oe, scl_oe, tx_ready, rx_valid, byte_irq, bus_col, rd_mode, ack_stat}, 32'h0);

    // detailed first transfer: ACK then NACK
    fork
      begin
        m_start;
        m_send_byte(RD_ADDR, a);
        chk("R2 address ACK", {31'h0, a}, 32'h0);
        m_recv_byte(1'b0, -1, 1'b1, v);
        m_recv_byte(1'b1, -1, 1'b1, v);
        m_stop;
      end
      begin
        while (!tx_ready) @(negedge clk);
        wait_cyc(60);
        chk("R3 SCL held while waiting", {30'h0, scl_oe, scl_w}, 32'h2);
        chk("R2 address byte out", {22'h0, rx_valid, rd_mode, rx_data}, {22'h0, 2'b11, RD_ADDR});
        chk("R8 irq on address byte", {31'h0, byte_irq}, 32'h1);
        pulse_irq_clr;
        wait_cyc(3);
        chk("R2 rx held until pop", {31'h0, rx_valid}, 32'h1);
        pulse_rx_ready;
        chk("R2 pop clears", {31'h0, rx_valid}, 32'h0);
        host_push(8'hA5, 1'b1);
        chk("R3 SCL released after load", {31'h0, scl_oe}, 32'h0);
        while (!tx_ready) @(negedge clk);
        chk("R6 stretch again after ACK", {30'h0, scl_oe, ack_stat}, 32'h2);
        chk("R8 irq on data byte", {31'h0, byte_irq}, 32'h1);
        pulse_irq_clr;
        host_push(8'h3C, 1'b1);
      end
    join
    chk("R5 NACK stored", {31'h0, ack_stat}, 32'h1);
    chk("R7 no stretch after NACK", {29'h0, scl_oe, rd_mode, tx_ready}, 32'h0);
    pulse_irq_clr;

    rd_xfer(8'hFF, 8'h00, 8'h81, 3, 1'b0);
    rd_xfer(8'h5E, 8'h00, 8'h00, 1, 1'b1);

    // R10: wrong address, then write direction to own address
    m_start;
    m_send_byte({7'h33, 1'b1}, a);
    chk("R10 wrong address NACK", {31'h0, a}, 32'h1);
    m_recv_byte(1'b1, -1, 1'b0, v);
    chk("R10 bus untouched", {23'h0, rx_valid, v}, 32'hFF);
    m_stop;
    m_start;
    m_send_byte({OWN, 1'b0}, a);
    chk("R10 write direction NACK", {30'h0, a, rd_mode}, 32'h2);
    m_stop;
    pulse_irq_clr;

    // R11: Start event flag
    start_irq_en = 1'b1;
    m_start;
    chk("R11 start sets irq", {31'h0, byte_irq}, 32'h1);
    m_stop;
    start_irq_en = 1'b0;
    pulse_irq_clr;
    chk("R8 irq_clr", {31'h0, byte_irq}, 32'h0);

    col_xfer(1'b1, 5);
    col_xfer(1'b0, 5);

    chk("R4 all bytes seen", exp_q.size(), 32'h0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule